// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer/Counter

This block is an 8-bit counter that advances on an enable tick picked by a clock-select field. The field can stop the counter, tick it on every system clock, or tick it on one of several power-of-two divided rates. Two compare channels watch the counter. Each channel has a write buffer in front of its active compare value. When the counter equals a channel's active value on a tick, the channel raises its flag and toggles its waveform pin. A third flag marks the counter's overflow or bottom turn. Each flag can be masked into one shared interrupt request.

Software reaches the block through one write port with six addresses. The addresses cover the counter, the two compare buffers, a control byte (rate and mode), the flag register and the mask register. Four modes are provided:
- a free-running up counter;
- an up counter that restarts after the value of channel A;
- a single-slope waveform mode;
- a dual-slope waveform mode that counts up to 0xFF and then back down to 0x00.

The two waveform modes defer compare updates until the counter is at its end-of-count value. The other two modes apply compare updates at once.

Top module: `tc8_dual_cmp`

## Requirements
- R1: After reset the counter reads 0x00, all three flags and all mask bits are 0, both waveform outputs are 0, and the clock-select value is 0 (stopped).
- R2: Control bits [2:0] pick the tick rate. Value 0 holds the counter. Value 1 ticks on every clock. Value k from 2 to 7 ticks once every 2^(DIV_STEP*(k-1)) clocks, which is every 4 clocks for k=3 at the default DIV_STEP=1.
- R3: In mode 0 (control bits [4:3]=00) and mode 2 (10), the counter counts up by one per tick and wraps from 0xFF to 0x00. The tick that wraps it sets the overflow flag, which is flag bit 0.
- R4: In mode 1 (01), the end-of-count value is the active compare value of channel A. The tick taken at that value returns the counter to 0x00, and the overflow flag stays clear while the counter stays below 0xFF.
- R5: In mode 3 (11), the counter counts up to 0xFF and then down to 0x00, then back up. The overflow flag is set by the tick taken at 0x00 while the counter is descending, and it is not set at 0xFF.
- R6: A tick taken while the counter equals channel A's (or B's) active compare value sets flag bit 1 (or bit 2) and toggles wave_a_o (or wave_b_o).
- R7: A compare write (address 1 for A, 2 for B) always loads the buffer. In modes 0 and 1 it also loads the active value at once. In modes 2 and 3 the active value takes the buffer only on a tick taken at the end-of-count value.
- R8: Writing the flag register (address 4) clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R9: irq_o is high exactly when some flag is set together with its mask bit. The mask register is at address 5, with the same bit layout as the flags.
- R10: A counter write (address 0) takes precedence over a tick in the same cycle. It also suppresses compare matches on the next tick only. Control sits at address 3.

Register addresses: 0 counter, 1 compare A, 2 compare B, 3 control, 4 flags, 5 mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| flags_o | output | 3 | Flags: bit 0 overflow, bit 1 match A, bit 2 match B |
| irq_o | output | 1 | Interrupt request |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |

## Verification
The bench builds the block with the default parameters: CNT_W=8, CS_W=3 and DIV_STEP=1. An 8-bit counter completes a full lap in 256 ticks. This keeps a whole-lap wrap, a buffered compare reload at the end of count, and a complete dual-slope descent to the bottom turn each within a few hundred clocks. DIV_STEP=1 makes clock-select 3 divide by four, so the divided rate can be confirmed exactly over 40 cycles.

// File: rtl/tc8_pkg.sv
// Shared definitions for the dual-compare timer: register addresses,
// flag bit positions and the counting modes.
package tc8_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CMPA  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_CMPB  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_FLAG  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_MASK  = 3'd5;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_OVF  = 0;
    localparam int FLAG_A    = 1;
    localparam int FLAG_B    = 2;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_CLRMATCH = 2'd1,
        MODE_FASTPWM  = 2'd2,
        MODE_DUALPWM  = 2'd3
    } tc_mode_e;
endpackage

// File: rtl/tc_prescale.sv
// Tick generator. A free-running prescale counter supplies divided ticks.
// The select value picks: 0 = none, 1 = every clock,
// k >= 2 = one tick every 2^(DIV_STEP*(k-1)) clocks.
// Assumes the select input comes from a register and does not glitch.
module tc_prescale #(
    parameter int CS_W     = 3,
    parameter int DIV_STEP = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CS_W-1:0] sel,
    output logic            tick
);
    localparam int NSEL  = 2 ** CS_W;
    localparam int PRE_W = DIV_STEP * (NSEL - 2);

    logic [PRE_W-1:0] pre_cnt;
    logic [NSEL-1:0]  sel_tick;

    // Free-running divider shared by all divided rates.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_cnt + 1'b1;
    end

    assign sel_tick[0] = 1'b0;
    assign sel_tick[1] = 1'b1;

    generate
        for (genvar g = 2; g < NSEL; g++) begin : g_tap
            assign sel_tick[g] = &pre_cnt[DIV_STEP*(g-1)-1:0];
        end
    endgenerate

    // Pick the tick for the selected rate.
    always_comb tick = sel_tick[sel];
endmodule

// File: rtl/tc_counter.sv
// Counter unit. It counts up and wraps (or restarts at top_val), or runs
// dual-slope up to top_val and down to zero. It reports end-of-count and
// overflow events. A load from the write port wins over a tick.
// Assumes top_val is MAX in the dual-slope mode.
module tc_counter
    import tc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tc_mode_e     mode,
    input  logic [W-1:0] top_val,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         at_top,
    output logic         ovf_evt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic going_down;

    // End-of-count and overflow decoding for the current tick.
    always_comb begin
        at_top  = (count == top_val);
        ovf_evt = 1'b0;
        if (tick && !load) begin
            if (mode == MODE_DUALPWM) ovf_evt = going_down && (count == '0);
            else                      ovf_evt = (count == CNT_MAX);
        end
    end

    // Counter and direction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            going_down <= 1'b0;
        end else if (load) begin
            count <= load_val;
            if (mode != MODE_DUALPWM) going_down <= 1'b0;
        end else if (tick) begin
            if (mode == MODE_DUALPWM) begin
                if (!going_down) begin
                    if (at_top) begin
                        going_down <= 1'b1;
                        count      <= count - 1'b1;
                    end else begin
                        count <= count + 1'b1;
                    end
                end else if (count == '0) begin
                    going_down <= 1'b0;
                    count      <= count + 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end else begin
                going_down <= 1'b0;
                count      <= at_top ? '0 : count + 1'b1;
            end
        end
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    // R5
    bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DUALPWM && ovf_evt) |=> (count == 1));

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_DUALPWM && ovf_evt) |=> (count == '0));
endmodule

// File: rtl/tc_compare.sv
// One compare channel. It holds a write buffer and an active value, detects
// a match on a tick, and toggles a waveform bit on each match.
// Assumes 'immediate' is high in the modes without deferred update.
module tc_compare #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         immediate,
    input  logic         update,
    input  logic         tick,
    input  logic         block,
    input  logic [W-1:0] count,
    output logic [W-1:0] active,
    output logic         match,
    output logic         wave
);
    logic [W-1:0] buffer_q;

    // Buffer and active value maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buffer_q <= '0;
            active   <= '0;
        end else begin
            if (wr) buffer_q <= wr_data;
            if (wr && immediate)         active <= wr_data;
            else if (!immediate && update) active <= buffer_q;
        end
    end

    // Match detection on a live, unblocked tick.
    always_comb match = tick && !block && (count == active);

    // Waveform toggles on every match.
    always_ff @(posedge clk) begin
        if (!rst_n)     wave <= 1'b0;
        else if (match) wave <= ~wave;
    end

    // R6
    wave_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (wave != $past(wave)));

    // R7
    deferred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!immediate && !update) |=> $stable(active));
endmodule

// File: rtl/tc8_dual_cmp.sv
// Dual-compare timer top. It holds the register file (control, flags, mask),
// the match blocking after a counter write, and the interrupt request, and it
// ties the prescaler, counter and two compare channels together.
// Assumes CS_W + 2 <= CNT_W so the control fields fit in one write word.
module tc8_dual_cmp
    import tc8_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int CS_W     = 3,
    parameter int DIV_STEP = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     count_o,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 irq_o,
    output logic                 wave_a_o,
    output logic                 wave_b_o
);
    localparam int NCH = 2;
    localparam int MODE_LO = CS_W;
    localparam int MODE_HI = CS_W + 1;

    logic [CS_W-1:0]      cs_q;
    tc_mode_e             mode_q;
    logic [NUM_FLAGS-1:0] flag_q, mask_q, flag_set;
    logic                 block_q;
    logic                 tick, load, at_top, ovf_evt, flag_wr;
    logic [CNT_W-1:0]     count, top_val;
    logic [CNT_W-1:0]     active [NCH];
    logic [NCH-1:0]       cmp_wr, match, wave;

    assign load    = wr_en && (wr_addr == REG_COUNT);
    assign flag_wr = wr_en && (wr_addr == REG_FLAG);

    tc_prescale #(.CS_W(CS_W), .DIV_STEP(DIV_STEP)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(cs_q), .tick(tick)
    );

    // End-of-count value depends on the mode.
    always_comb top_val = (mode_q == MODE_CLRMATCH) ? active[0] : '1;

    tc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q),
        .top_val(top_val), .load(load), .load_val(wr_data),
        .count(count), .at_top(at_top), .ovf_evt(ovf_evt)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            assign cmp_wr[ch] = wr_en &&
                (wr_addr == ((ch == 0) ? REG_CMPA : REG_CMPB));
            tc_compare #(.W(CNT_W)) u_cmp (
                .clk(clk), .rst_n(rst_n), .wr(cmp_wr[ch]), .wr_data(wr_data),
                .immediate(!mode_q[1]), .update(tick && at_top), .tick(tick),
                .block(block_q || load), .count(count), .active(active[ch]),
                .match(match[ch]), .wave(wave[ch])
            );
        end
    endgenerate

    // Control and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= '0;
            mode_q <= MODE_NORMAL;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_CTRL) begin
                cs_q   <= wr_data[CS_W-1:0];
                mode_q <= tc_mode_e'(wr_data[MODE_HI:MODE_LO]);
            end
            if (wr_addr == REG_MASK) mask_q <= wr_data[NUM_FLAGS-1:0];
        end
    end

    // Match blocking: armed by a counter write, spent by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    block_q <= 1'b0;
        else if (load) block_q <= 1'b1;
        else if (tick) block_q <= 1'b0;
    end

    // Flag events gathered into register bit order.
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_OVF] = ovf_evt;
        flag_set[FLAG_A]   = match[0];
        flag_set[FLAG_B]   = match[1];
    end

    // Flags: set by events, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else flag_q <= flag_set |
            (flag_q & ~({NUM_FLAGS{flag_wr}} & wr_data[NUM_FLAGS-1:0]));
    end

    assign count_o  = count;
    assign flags_o  = flag_q;
    assign irq_o    = |(flag_q & mask_q);
    assign wave_a_o = wave[0];
    assign wave_b_o = wave[1];

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && wr_data[FLAG_OVF] && !ovf_evt) |=> !flag_q[FLAG_OVF]);

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !wr_data[FLAG_A] && flag_q[FLAG_A]) |=> flag_q[FLAG_A]);

    // R10
    load_blocks_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (match == '0));
endmodule

// File: tb/sim_tc8_dual_cmp.sv
module sim_tc8_dual_cmp;
    import tc8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count_o;
    logic [2:0] flags_o;
    logic       irq_o, wave_a_o, wave_b_o;

    localparam int K_CNT = 0, K_FLG = 1, K_IRQ = 2, K_WA = 3, K_WB = 4;

    typedef struct {
        int    at;
        int    kind;
        int    msk;
        int    exp;
        string req;
    } item_t;

    item_t sb[$];
    item_t mon_it;
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    got;
    bit    done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tc8_dual_cmp u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .flags_o(flags_o),
        .irq_o(irq_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o)
    );

    function automatic int sample(int k);
        case (k)
            K_CNT:   return int'(count_o);
            K_FLG:   return int'(flags_o);
            K_IRQ:   return int'(irq_o);
            K_WA:    return int'(wave_a_o);
            default: return int'(wave_b_o);
        endcase
    endfunction

    task automatic expect_at(int at, int kind, int msk, int exp, string req);
        item_t it;
        int i = 0;
        it.at = at; it.kind = kind; it.msk = msk; it.exp = exp; it.req = req;
        while (i < sb.size() && sb[i].at <= at) i++;
        sb.insert(i, it);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: compare queued expectations when their cycle comes up.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            mon_it = sb.pop_front();
            n_cmp++;
            got = sample(mon_it.kind) & mon_it.msk;
            if (mon_it.at != cyc || got != mon_it.exp) begin
                n_bad++;
                $display("FAIL %s: kind %0d actual=%0h expected=%0h (cycle %0d)",
                         mon_it.req, mon_it.kind, got, mon_it.exp, cyc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int t, c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t = cyc;
        // R1 reset state
        expect_at(t + 1, K_CNT, 8'hFF, 0, "R1");
        expect_at(t + 1, K_FLG, 7, 0, "R1");
        expect_at(t + 1, K_IRQ, 1, 0, "R1");
        expect_at(t + 1, K_WA, 1, 0, "R1");
        expect_at(t + 1, K_WB, 1, 0, "R1");
        expect_at(t + 6, K_CNT, 8'hFF, 0, "R2 stopped after reset");
        wait_until(t + 7);

        // R6 matches in normal mode, every-clock ticks
        wr(REG_CMPA, 8'd5);
        wr(REG_CMPB, 8'd9);
        wr(REG_MASK, 8'h07);
        wr(REG_CTRL, 8'h01);
        t = cyc;
        expect_at(t + 3, K_CNT, 8'hFF, 3, "R3 count up");
        expect_at(t + 5, K_FLG, 7, 0, "R6 no match yet");
        expect_at(t + 6, K_FLG, 7, 2, "R6 match A");
        expect_at(t + 6, K_IRQ, 1, 1, "R9 irq");
        expect_at(t + 6, K_WA, 1, 1, "R6 wave A");
        expect_at(t + 10, K_FLG, 7, 6, "R6 match B");
        expect_at(t + 10, K_WB, 1, 1, "R6 wave B");
        wait_until(t + 12);

        // R2 stop holds count
        wr(REG_CTRL, 8'h00);
        c = int'(count_o);
        expect_at(cyc + 5, K_CNT, 8'hFF, c, "R2 hold");
        wait_until(cyc + 6);

        // R8 write-one-to-clear, R9 masking
        wr(REG_FLAG, 8'h00);
        expect_at(cyc + 1, K_FLG, 7, 6, "R8 zero no effect");
        wr(REG_FLAG, 8'h02);
        expect_at(cyc + 1, K_FLG, 7, 4, "R8 clear A only");
        wr(REG_MASK, 8'h02);
        expect_at(cyc + 1, K_IRQ, 1, 0, "R9 masked");
        wr(REG_MASK, 8'h04);
        expect_at(cyc + 1, K_IRQ, 1, 1, "R9 unmasked");
        wait_until(cyc + 2);

        // R3 overflow on wrap
        wr(REG_FLAG, 8'h07);
        wr(REG_COUNT, 8'hFD);
        wr(REG_CTRL, 8'h01);
        t = cyc;
        expect_at(t + 2, K_CNT, 8'hFF, 8'hFF, "R3 at max");
        expect_at(t + 2, K_FLG, 1, 0, "R3 no ovf yet");
        expect_at(t + 3, K_CNT, 8'hFF, 0, "R3 wrap");
        expect_at(t + 3, K_FLG, 1, 1, "R3 ovf flag");
        wait_until(t + 4);

        // R10 counter write blocks the next tick's match only
        wr(REG_CTRL, 8'h00);
        wr(REG_FLAG, 8'h07);
        wr(REG_CMPA, 8'h20);
        wr(REG_CTRL, 8'h01);
        wr(REG_COUNT, 8'h20);
        t = cyc;
        expect_at(t + 1, K_CNT, 8'hFF, 8'h21, "R10 write wins");
        expect_at(t + 1, K_FLG, 2, 0, "R10 blocked");
        wait_until(t + 2);
        wr(REG_FLAG, 8'h07);
        wr(REG_COUNT, 8'h1F);
        t = cyc;
        expect_at(t + 1, K_FLG, 2, 0, "R10 blocked tick");
        expect_at(t + 2, K_FLG, 2, 2, "R10 unblocked");
        wait_until(t + 3);

        // R2 divide by four (select 3)
        wr(REG_CTRL, 8'h00);
        wr(REG_COUNT, 8'h00);
        wr(REG_CTRL, 8'h03);
        t = cyc;
        wait_until(t + 1);
        c = int'(count_o);
        expect_at(t + 41, K_CNT, 8'hFF, (c + 10) & 8'hFF, "R2 divided rate");
        wait_until(t + 42);

        // R4 restart after compare A
        wr(REG_CTRL, 8'h00);
        wr(REG_CMPA, 8'h03);
        wr(REG_COUNT, 8'h00);
        wr(REG_FLAG, 8'h07);
        wr(REG_CTRL, 8'h09);
        t = cyc;
        expect_at(t + 3, K_CNT, 8'hFF, 3, "R4 reach top");
        expect_at(t + 4, K_CNT, 8'hFF, 0, "R4 restart");
        expect_at(t + 4, K_FLG, 2, 2, "R4 match at top");
        expect_at(t + 9, K_CNT, 8'hFF, 1, "R4 period");
        expect_at(t + 12, K_FLG, 1, 0, "R4 no ovf");
        wait_until(t + 13);

        // R7 deferred compare update in single-slope mode
        wr(REG_CTRL, 8'h10);
        wr(REG_COUNT, 8'h00);
        wr(REG_CMPA, 8'h80);
        wr(REG_FLAG, 8'h07);
        wr(REG_CTRL, 8'h11);
        t = cyc;
        expect_at(t + 4, K_FLG, 2, 2, "R7 old value active");
        expect_at(t + 256, K_CNT, 8'hFF, 0, "R3 wrap in mode 2");
        wait_until(t + 300);
        wr(REG_FLAG, 8'h07);
        expect_at(t + 384, K_FLG, 2, 0, "R7 before new match");
        expect_at(t + 385, K_FLG, 2, 2, "R7 new value after top");
        wait_until(t + 386);

        // R5 dual-slope
        wr(REG_CTRL, 8'h18);
        wr(REG_COUNT, 8'hFD);
        wr(REG_FLAG, 8'h07);
        wr(REG_CTRL, 8'h19);
        t = cyc;
        expect_at(t + 2, K_CNT, 8'hFF, 8'hFF, "R5 top");
        expect_at(t + 3, K_CNT, 8'hFF, 8'hFE, "R5 turn down");
        expect_at(t + 3, K_FLG, 1, 0, "R5 no ovf at top");
        expect_at(t + 4, K_CNT, 8'hFF, 8'hFD, "R5 descending");
        expect_at(t + 257, K_CNT, 8'hFF, 0, "R5 bottom");
        expect_at(t + 257, K_FLG, 1, 0, "R5 ovf not yet");
        expect_at(t + 258, K_CNT, 8'hFF, 1, "R5 turn up");
        expect_at(t + 258, K_FLG, 1, 1, "R5 ovf at bottom");
        wait_until(t + 260);

        while (sb.size() > 0) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule